// File: doc/BRIEF.md
# Switch CPU-port tag bridge

This block sits on the byte-wide Ethernet path between a host MAC and the CPU-facing port of a switch. Each direction uses a valid/ready/last stream. On the way out (egress) it places a two-byte switch tag after the twelve MAC address bytes. The tag names one destination port and carries a priority. On the way in (ingress) it reads the tag that the switch placed in the same position. It checks the version and source-port fields of that tag. A frame that passes the checks leaves with the tag removed, and the tag fields are driven on sideband outputs for as long as the frame is being sent. A frame that fails is swallowed whole. Three counters report how many frames were forwarded out, forwarded in, and dropped on the way in.

The egress side is a four-state machine:
- `EG_ADDR` passes the address bytes through.
- `EG_ADDR` moves to `EG_HDR_HI` after the twelfth byte when that byte is not the last.
- `EG_ADDR` stays put if a frame ends early.
- `EG_HDR_HI` moves to `EG_HDR_LO`, and `EG_HDR_LO` moves to `EG_BODY`. Each of these moves happens as the corresponding tag byte is accepted downstream.
- `EG_BODY` passes bytes through and returns to `EG_ADDR` on the last byte.

The ingress side is also a four-state machine:
- `IN_COLLECT` buffers the first fourteen bytes without emitting anything.
- On the fourteenth byte, `IN_COLLECT` moves to `IN_REPLAY` when the tag is good and to `IN_DISCARD` when it is bad.
- `IN_COLLECT` stays put, counting a drop, when a frame ends within those fourteen bytes.
- `IN_REPLAY` sends the twelve buffered address bytes and then moves to `IN_BODY`.
- `IN_BODY` passes bytes through and returns to `IN_COLLECT` on the last byte.
- `IN_DISCARD` accepts bytes until the last one and then returns to `IN_COLLECT`.

Top module: `cpu_tag_bridge`

## Requirements
- R1: Egress frames longer than 12 bytes come out with two tag bytes, most significant first, placed right after byte 12. All other bytes keep their order and value, and `last` stays on the final byte.
- R2: The egress tag high byte is {2'b10, priority[2:0], 3'b000}. The low byte is {1'b1, bitmap[6:0]}, where bitmap has only bit (port index + 1) set for index 0..5 and is all zero for index 6 or 7. Port index and priority are sampled with the first byte of the frame.
- R3: An egress frame whose `last` falls within its first 12 bytes leaves unchanged, with no tag.
- R4: A good ingress frame leaves as its 12 address bytes followed directly by input byte 15 onward. It is two bytes shorter than the input, with `last` on its final byte.
- R5: While a good ingress frame is output, the sideband outputs hold values decoded from the tag (tag bit 15 is the first received tag byte's MSB):
  - source port index = tag[2:0] − 1 (always below 6);
  - priority = tag[13:11];
  - frame type = tag[10:6];
  - VLAN flag = tag[3].
  These values do not change before the frame's last byte is accepted.
- R6: An ingress frame whose tag[15:14] is not 2 produces no output byte.
- R7: An ingress frame produces no output byte in any of these cases:
  - its tag[2:0] is 0;
  - its tag[2:0] is 7;
  - `in_port_en` bit (tag[2:0] − 1) is clear.
- R8: An ingress frame whose `last` arrives at or before its 14th byte produces no output byte. No output is presented before 14 bytes of a frame have been accepted.
- R9: Under downstream stall, a presented output byte holds its value and `last` until accepted. Bytes are neither lost nor duplicated.
- R10: `eg_frames` and `in_frames` count output frames. `in_drops` counts dropped ingress frames. Each rises by exactly one per event.
- R11: After reset both output valids are low, all counters are zero and the ingress input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eg_s_data | input | 8 | Egress byte from host |
| eg_s_valid | input | 1 | Egress input valid |
| eg_s_last | input | 1 | Egress input final byte |
| eg_s_ready | output | 1 | Egress input accepted |
| eg_port | input | 3 | Egress destination user port index |
| eg_prio | input | 3 | Egress priority |
| eg_m_data | output | 8 | Egress byte to switch |
| eg_m_valid | output | 1 | Egress output valid |
| eg_m_last | output | 1 | Egress output final byte |
| eg_m_ready | input | 1 | Switch accepts egress byte |
| in_s_data | input | 8 | Ingress byte from switch |
| in_s_valid | input | 1 | Ingress input valid |
| in_s_last | input | 1 | Ingress input final byte |
| in_s_ready | output | 1 | Ingress input accepted |
| in_port_en | input | 6 | Present user ports, bit i for index i |
| in_m_data | output | 8 | Ingress byte to host |
| in_m_valid | output | 1 | Ingress output valid |
| in_m_last | output | 1 | Ingress output final byte |
| in_m_ready | input | 1 | Host accepts ingress byte |
| in_src_port | output | 3 | Source user port index |
| in_prio | output | 3 | Received priority |
| in_ftype | output | 5 | Received frame type |
| in_vlan | output | 1 | Received frame was VLAN tagged |
| eg_frames | output | 16 | Egress frames forwarded |
| in_frames | output | 16 | Ingress frames forwarded |
| in_drops | output | 16 | Ingress frames dropped |

## Verification
The hold-under-stall properties assume the upstream source keeps valid, data and last steady until its byte is accepted. This matters because in the pass-through states the output is the input. The properties also assume that `eg_port`, `eg_prio` and `in_port_en` do not change during a frame. The stimulus meets these assumptions:
- bytes are driven at the falling edge and held until ready is seen;
- idle gaps are inserted only between bytes;
- sideband inputs change only between frames.

The downstream ready is randomly withheld, so the properties are exercised.

// File: rtl/tag_pkg.sv
package tag_pkg;
    localparam int ADDR_BYTES  = 12;
    localparam int PRE_BYTES   = ADDR_BYTES + 2;
    localparam int POS_W       = $clog2(PRE_BYTES);
    localparam int USER_PORTS  = 6;
    localparam logic [1:0] TAG_VER = 2'b10;
    localparam logic [POS_W-1:0] LAST_ADDR = POS_W'(ADDR_BYTES - 1);
    localparam logic [POS_W-1:0] HI_POS    = POS_W'(ADDR_BYTES);
    localparam logic [POS_W-1:0] LO_POS    = POS_W'(ADDR_BYTES + 1);

    typedef enum logic [1:0] {EG_ADDR, EG_HDR_HI, EG_HDR_LO, EG_BODY} eg_state_t;
    typedef enum logic [1:0] {IN_COLLECT, IN_REPLAY, IN_BODY, IN_DISCARD} in_state_t;

    typedef struct packed {
        logic [2:0] port;
        logic [2:0] prio;
        logic [4:0] ftype;
        logic       vlan;
    } in_meta_t;

    function automatic logic [15:0] build_eg_tag(input logic [2:0] idx, input logic [2:0] prio);
        logic [8:0] sh;
        sh = 9'd1 << ({1'b0, idx} + 4'd1);
        return {TAG_VER, prio, 3'b000, 1'b1, sh[6:0]};
    endfunction
endpackage

// File: rtl/tag_inserter.sv
module tag_inserter
    import tag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    input  logic [2:0] port_idx,
    input  logic [2:0] prio,
    output logic [7:0] m_data,
    output logic       m_valid,
    output logic       m_last,
    input  logic       m_ready
);
    eg_state_t        state, nxt;
    logic [POS_W-1:0] pos;
    logic [15:0]      tag;
    logic             in_hs;

    assign in_hs = s_valid && s_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EG_ADDR;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
            tag <= '0;
        end else begin
            if (state == EG_ADDR && in_hs) begin
                if (pos == '0) tag <= build_eg_tag(port_idx, prio);
                pos <= (s_last || pos == LAST_ADDR) ? '0 : pos + 1'b1;
            end
        end
    end

    always_comb begin
        nxt     = state;
        m_data  = s_data;
        m_valid = s_valid;
        m_last  = s_last;
        s_ready = m_ready;
        unique case (state)
            EG_ADDR: begin
                if (in_hs && !s_last && pos == LAST_ADDR) nxt = EG_HDR_HI;
            end
            EG_HDR_HI: begin
                m_data  = tag[15:8];
                m_valid = 1'b1;
                m_last  = 1'b0;
                s_ready = 1'b0;
                if (m_ready) nxt = EG_HDR_LO;
            end
            EG_HDR_LO: begin
                m_data  = tag[7:0];
                m_valid = 1'b1;
                m_last  = 1'b0;
                s_ready = 1'b0;
                if (m_ready) nxt = EG_BODY;
            end
            EG_BODY: begin
                if (in_hs && s_last) nxt = EG_ADDR;
            end
            default: nxt = EG_ADDR;
        endcase
    end
endmodule

// File: rtl/tag_stripper.sv
module tag_stripper
    import tag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            s_data,
    input  logic                  s_valid,
    input  logic                  s_last,
    output logic                  s_ready,
    input  logic [USER_PORTS-1:0] port_en,
    output logic [7:0]            m_data,
    output logic                  m_valid,
    output logic                  m_last,
    input  logic                  m_ready,
    output in_meta_t              meta,
    output logic                  drop_pulse
);
    in_state_t        state, nxt;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] rpos;
    logic [7:0]       abuf [ADDR_BYTES];
    logic [7:0]       tag_hi;
    logic [15:0]      tag_w;
    logic [2:0]       src;
    logic [2:0]       src_idx;
    logic             tag_ok;
    logic             hdr_done;

    assign tag_w    = {tag_hi, s_data};
    assign src      = tag_w[2:0];
    assign src_idx  = src - 3'd1;
    assign tag_ok   = (tag_w[15:14] == TAG_VER) && (src != 3'd0) &&
                      (int'(src) <= USER_PORTS) && port_en[src_idx];
    assign hdr_done = (state == IN_COLLECT) && s_valid && !s_last && (pos == LO_POS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IN_COLLECT;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (state == IN_COLLECT && s_valid && pos < HI_POS) abuf[pos] <= s_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos    <= '0;
            rpos   <= '0;
            tag_hi <= '0;
            meta   <= '0;
        end else begin
            if (state == IN_COLLECT && s_valid) begin
                if (pos == HI_POS) tag_hi <= s_data;
                pos <= (s_last || pos == LO_POS) ? '0 : pos + 1'b1;
            end
            if (hdr_done && tag_ok)
                meta <= '{port: src_idx, prio: tag_w[13:11], ftype: tag_w[10:6], vlan: tag_w[3]};
            if (state == IN_REPLAY) begin
                if (m_ready) rpos <= rpos + 1'b1;
            end else begin
                rpos <= '0;
            end
        end
    end

    always_comb begin
        nxt        = state;
        m_data     = s_data;
        m_valid    = 1'b0;
        m_last     = 1'b0;
        s_ready    = 1'b1;
        drop_pulse = 1'b0;
        unique case (state)
            IN_COLLECT: begin
                if (s_valid && s_last) begin
                    drop_pulse = 1'b1;
                end else if (hdr_done) begin
                    if (tag_ok) begin
                        nxt = IN_REPLAY;
                    end else begin
                        nxt        = IN_DISCARD;
                        drop_pulse = 1'b1;
                    end
                end
            end
            IN_REPLAY: begin
                s_ready = 1'b0;
                m_valid = 1'b1;
                m_data  = abuf[rpos];
                if (m_ready && rpos == LAST_ADDR) nxt = IN_BODY;
            end
            IN_BODY: begin
                m_valid = s_valid;
                m_last  = s_last;
                s_ready = m_ready;
                if (s_valid && m_ready && s_last) nxt = IN_COLLECT;
            end
            IN_DISCARD: begin
                if (s_valid && s_last) nxt = IN_COLLECT;
            end
            default: nxt = IN_COLLECT;
        endcase
    end
endmodule

// File: rtl/event_counter.sv
module event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/cpu_tag_bridge.sv
module cpu_tag_bridge
    import tag_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       eg_s_data,
    input  logic             eg_s_valid,
    input  logic             eg_s_last,
    output logic             eg_s_ready,
    input  logic [2:0]       eg_port,
    input  logic [2:0]       eg_prio,
    output logic [7:0]       eg_m_data,
    output logic             eg_m_valid,
    output logic             eg_m_last,
    input  logic             eg_m_ready,
    input  logic [7:0]       in_s_data,
    input  logic             in_s_valid,
    input  logic             in_s_last,
    output logic             in_s_ready,
    input  logic [5:0]       in_port_en,
    output logic [7:0]       in_m_data,
    output logic             in_m_valid,
    output logic             in_m_last,
    input  logic             in_m_ready,
    output logic [2:0]       in_src_port,
    output logic [2:0]       in_prio,
    output logic [4:0]       in_ftype,
    output logic             in_vlan,
    output logic [CNT_W-1:0] eg_frames,
    output logic [CNT_W-1:0] in_frames,
    output logic [CNT_W-1:0] in_drops
);
    localparam int N_CNT = 3;

    in_meta_t         meta;
    logic             in_drop;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    tag_inserter u_ins (
        .clk(clk), .rst_n(rst_n),
        .s_data(eg_s_data), .s_valid(eg_s_valid), .s_last(eg_s_last), .s_ready(eg_s_ready),
        .port_idx(eg_port), .prio(eg_prio),
        .m_data(eg_m_data), .m_valid(eg_m_valid), .m_last(eg_m_last), .m_ready(eg_m_ready)
    );

    tag_stripper u_strip (
        .clk(clk), .rst_n(rst_n),
        .s_data(in_s_data), .s_valid(in_s_valid), .s_last(in_s_last), .s_ready(in_s_ready),
        .port_en(in_port_en),
        .m_data(in_m_data), .m_valid(in_m_valid), .m_last(in_m_last), .m_ready(in_m_ready),
        .meta(meta), .drop_pulse(in_drop)
    );

    assign in_src_port = meta.port;
    assign in_prio     = meta.prio;
    assign in_ftype    = meta.ftype;
    assign in_vlan     = meta.vlan;

    assign cnt_inc[0] = eg_m_valid && eg_m_ready && eg_m_last;
    assign cnt_inc[1] = in_m_valid && in_m_ready && in_m_last;
    assign cnt_inc[2] = in_drop;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        event_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(cnt_inc[g]), .value(cnt_val[g])
        );
    end

    assign eg_frames = cnt_val[0];
    assign in_frames = cnt_val[1];
    assign in_drops  = cnt_val[2];
endmodule

// File: rtl/tag_bridge_checker.sv
module tag_bridge_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       eg_m_data,
    input logic             eg_m_valid,
    input logic             eg_m_last,
    input logic             eg_m_ready,
    input logic [7:0]       in_m_data,
    input logic             in_m_valid,
    input logic             in_m_last,
    input logic             in_m_ready,
    input logic [2:0]       in_src_port,
    input logic [2:0]       in_prio,
    input logic [4:0]       in_ftype,
    input logic             in_vlan,
    input logic [CNT_W-1:0] eg_frames,
    input logic [CNT_W-1:0] in_frames,
    input logic [CNT_W-1:0] in_drops
);
    assert_eg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eg_m_valid && !eg_m_ready |=> eg_m_valid && $stable(eg_m_data) && $stable(eg_m_last));

    assert_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_m_valid && !in_m_ready |=> in_m_valid && $stable(in_m_data) && $stable(in_m_last));

    assert_src_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_m_valid |-> in_src_port < 3'd6);

    assert_meta_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_m_valid && !(in_m_ready && in_m_last) |=>
            $stable({in_src_port, in_prio, in_ftype, in_vlan}));

    assert_eg_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eg_m_valid && eg_m_ready && eg_m_last |=> eg_frames == $past(eg_frames) + 1'b1);

    assert_in_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_m_valid && in_m_ready && in_m_last |=> in_frames == $past(in_frames) + 1'b1);

    assert_drop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_drops == $past(in_drops) || in_drops == $past(in_drops) + 1'b1);
endmodule

bind cpu_tag_bridge tag_bridge_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .eg_m_data(eg_m_data), .eg_m_valid(eg_m_valid), .eg_m_last(eg_m_last), .eg_m_ready(eg_m_ready),
    .in_m_data(in_m_data), .in_m_valid(in_m_valid), .in_m_last(in_m_last), .in_m_ready(in_m_ready),
    .in_src_port(in_src_port), .in_prio(in_prio), .in_ftype(in_ftype), .in_vlan(in_vlan),
    .eg_frames(eg_frames), .in_frames(in_frames), .in_drops(in_drops)
);

// File: tb/sim_cpu_tag_bridge.sv
module sim_cpu_tag_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  eg_s_data = '0;
    logic        eg_s_valid = 1'b0, eg_s_last = 1'b0, eg_s_ready;
    logic [2:0]  eg_port = '0, eg_prio = '0;
    logic [7:0]  eg_m_data;
    logic        eg_m_valid, eg_m_last, eg_m_ready = 1'b1;
    logic [7:0]  in_s_data = '0;
    logic        in_s_valid = 1'b0, in_s_last = 1'b0, in_s_ready;
    logic [5:0]  in_port_en = 6'h3f;
    logic [7:0]  in_m_data;
    logic        in_m_valid, in_m_last, in_m_ready = 1'b1;
    logic [2:0]  in_src_port, in_prio;
    logic [4:0]  in_ftype;
    logic        in_vlan;
    logic [15:0] eg_frames, in_frames, in_drops;

    cpu_tag_bridge u0 (.*);

    always #5ns clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int exp_eg_frames = 0, exp_in_frames = 0, exp_drops = 0;
    bit stall = 1'b0, done = 1'b0, in_sof = 1'b1;
    string eg_req = "R1", in_req = "R4";
    logic [8:0]  eg_exp[$];
    logic [8:0]  in_exp[$];
    logic [11:0] meta_exp[$];
    logic [7:0]  fq[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // egress sink: compare every accepted byte with the model queue
    initial forever begin
        @(negedge clk);
        eg_m_ready = stall ? ($urandom % 3 != 0) : 1'b1;
        #3ns;
        if (rst_n && eg_m_valid && eg_m_ready) begin
            if (eg_exp.size() == 0) chk(0, {eg_req, " unexpected egress byte"}, {eg_m_last, eg_m_data}, 0);
            else begin
                logic [8:0] e;
                e = eg_exp.pop_front();
                chk({eg_m_last, eg_m_data} == e, eg_req, {eg_m_last, eg_m_data}, e);
            end
        end
    end

    // ingress sink with sideband check on the first byte of each frame
    initial forever begin
        @(negedge clk);
        in_m_ready = stall ? ($urandom % 3 != 0) : 1'b1;
        #3ns;
        if (rst_n && in_m_valid && in_m_ready) begin
            if (in_exp.size() == 0) chk(0, {in_req, " unexpected ingress byte"}, {in_m_last, in_m_data}, 0);
            else begin
                logic [8:0] e;
                e = in_exp.pop_front();
                chk({in_m_last, in_m_data} == e, in_req, {in_m_last, in_m_data}, e);
            end
            if (in_sof && meta_exp.size() != 0) begin
                logic [11:0] m;
                m = meta_exp.pop_front();
                chk({in_src_port, in_prio, in_ftype, in_vlan} == m, "R5 sideband",
                    {in_src_port, in_prio, in_ftype, in_vlan}, m);
            end
            in_sof = in_m_last;
        end
    end

    task automatic eg_push(input logic [7:0] d, input bit l);
        @(negedge clk);
        if ($urandom % 4 == 0) begin eg_s_valid = 1'b0; @(negedge clk); end
        eg_s_data = d; eg_s_last = l; eg_s_valid = 1'b1;
        #2ns;
        while (!eg_s_ready) begin @(negedge clk); #2ns; end
    endtask

    task automatic in_push(input logic [7:0] d, input bit l);
        @(negedge clk);
        if ($urandom % 4 == 0) begin in_s_valid = 1'b0; @(negedge clk); end
        in_s_data = d; in_s_last = l; in_s_valid = 1'b1;
        #2ns;
        while (!in_s_ready) begin @(negedge clk); #2ns; end
    endtask

    task automatic send_eg(input int len, input logic [2:0] port, input logic [2:0] prio, input logic [7:0] seed);
        logic [6:0] bm;
        bm = (port <= 3'd5) ? (7'd1 << (port + 3'd1)) : 7'd0;
        for (int i = 0; i < len; i++) begin
            if (len > 12 && i == 12) begin
                eg_exp.push_back({1'b0, 2'b10, prio, 3'b000});
                eg_exp.push_back({1'b0, 1'b1, bm});
            end
            eg_exp.push_back({i == len - 1, 8'(seed + i)});
        end
        exp_eg_frames++;
        @(negedge clk);
        eg_port = port; eg_prio = prio;
        for (int i = 0; i < len; i++) eg_push(8'(seed + i), i == len - 1);
        @(negedge clk);
        eg_s_valid = 1'b0;
    endtask

    // builds fq: 12 address bytes, tag, then payload up to len
    task automatic mk_in(input int len, input logic [15:0] tag, input logic [7:0] seed);
        fq.delete();
        for (int i = 0; i < len; i++) begin
            if (i == 12)      fq.push_back(tag[15:8]);
            else if (i == 13) fq.push_back(tag[7:0]);
            else              fq.push_back(8'(seed + i));
        end
    endtask

    task automatic send_in();
        logic [15:0] tag;
        logic [2:0]  s;
        bit          good;
        int          len;
        len  = fq.size();
        tag  = (len >= 14) ? {fq[12], fq[13]} : 16'h0;
        s    = tag[2:0];
        good = (len > 14) && tag[15:14] == 2'b10 && s != 3'd0 && s != 3'd7 && in_port_en[s - 3'd1];
        if (good) begin
            for (int i = 0; i < len; i++)
                if (i < 12 || i > 13) in_exp.push_back({i == len - 1, fq[i]});
            meta_exp.push_back({s - 3'd1, tag[13:11], tag[10:6], tag[3]});
            exp_in_frames++;
        end else begin
            exp_drops++;
        end
        for (int i = 0; i < len; i++) in_push(fq[i], i == len - 1);
        @(negedge clk);
        in_s_valid = 1'b0;
    endtask

    task automatic drain();
        while (eg_exp.size() != 0 || in_exp.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3ns;
        // R11 reset state
        chk(eg_m_valid == 0, "R11 eg valid", eg_m_valid, 0);
        chk(in_m_valid == 0, "R11 in valid", in_m_valid, 0);
        chk(in_s_ready == 1, "R11 in ready", in_s_ready, 1);
        chk(eg_frames == 0 && in_frames == 0 && in_drops == 0, "R11 counters",
            {eg_frames, in_frames, in_drops}, 0);

        eg_req = "R1";  send_eg(20, 3'd0, 3'd0, 8'h10); drain();
        eg_req = "R2";  send_eg(30, 3'd4, 3'd7, 8'h40); drain();
        eg_req = "R2";  send_eg(16, 3'd5, 3'd2, 8'h70); drain();
        eg_req = "R2";  send_eg(14, 3'd6, 3'd5, 8'h90); drain();
        eg_req = "R3";  send_eg(12, 3'd1, 3'd1, 8'hA0); drain();
        eg_req = "R3";  send_eg(5,  3'd2, 3'd3, 8'hB0); drain();
        eg_req = "R1";  send_eg(13, 3'd3, 3'd4, 8'hC0); drain();

        in_req = "R4"; mk_in(40, {2'b10, 3'd3, 5'd5, 2'b00, 1'b1, 3'd1}, 8'h20); send_in(); drain();
        in_req = "R4"; mk_in(15, {2'b10, 3'd6, 5'd17, 2'b00, 1'b0, 3'd6}, 8'h30); send_in(); drain();
        in_req = "R6"; mk_in(30, {2'b01, 3'd0, 5'd0, 2'b00, 1'b0, 3'd2}, 8'h50); send_in(); drain();
        in_req = "R6"; mk_in(30, {2'b11, 3'd0, 5'd0, 2'b00, 1'b0, 3'd2}, 8'h51); send_in(); drain();
        in_req = "R7"; mk_in(25, {2'b10, 3'd1, 5'd1, 2'b00, 1'b0, 3'd0}, 8'h60); send_in(); drain();
        in_req = "R7"; mk_in(25, {2'b10, 3'd1, 5'd1, 2'b00, 1'b0, 3'd7}, 8'h61); send_in(); drain();
        in_port_en = 6'b111011;
        in_req = "R7"; mk_in(25, {2'b10, 3'd1, 5'd1, 2'b00, 1'b0, 3'd3}, 8'h62); send_in(); drain();
        in_req = "R7"; mk_in(22, {2'b10, 3'd2, 5'd9, 2'b00, 1'b1, 3'd4}, 8'h63); send_in(); drain();
        in_port_en = 6'h3f;
        in_req = "R8"; mk_in(10, 16'h8001, 8'h70); send_in(); drain();
        in_req = "R8"; mk_in(14, 16'h8001, 8'h71); send_in(); drain();
        in_req = "R4"; mk_in(18, {2'b10, 3'd1, 5'd2, 2'b00, 1'b0, 3'd5}, 8'h72); send_in(); drain();

        // R9 stalls on both directions, run concurrently
        stall = 1'b1;
        eg_req = "R9"; in_req = "R9";
        fork
            begin send_eg(33, 3'd2, 3'd6, 8'h05); send_eg(17, 3'd0, 3'd1, 8'h15); end
            begin
                mk_in(37, {2'b10, 3'd5, 5'd31, 2'b00, 1'b1, 3'd2}, 8'h80); send_in();
                mk_in(9, 16'h8002, 8'h81); send_in();
                mk_in(21, {2'b10, 3'd7, 5'd3, 2'b00, 1'b0, 3'd6}, 8'h82); send_in();
            end
        join
        drain();
        stall = 1'b0;

        #3ns;
        chk(eg_exp.size() == 0 && in_exp.size() == 0, "R9 all bytes delivered",
            eg_exp.size() + in_exp.size(), 0);
        chk(eg_frames == 16'(exp_eg_frames), "R10 eg_frames", eg_frames, exp_eg_frames);
        chk(in_frames == 16'(exp_in_frames), "R10 in_frames", in_frames, exp_in_frames);
        chk(in_drops == 16'(exp_drops), "R10 in_drops", in_drops, exp_drops);
        done = 1'b1;
        finish_run();
    end
endmodule